// File: doc/BRIEF.md
# CPU Idle Mode Controller

This block owns the power-control register of an 8-bit microcontroller and turns its idle request bit into a CPU-halt signal. Firmware enters idle by writing the register with the idle bit set. The CPU is then held. Timers, the serial port and the interrupt logic keep their clock, so they continue to run. A pending interrupt ends idle. The CPU-halt output falls in the same cycle the interrupt is seen. The hardware clears the idle bit at the next clock edge. The CPU then services the interrupt and continues with the instruction that follows the write that requested idle.

The register is one byte on the special-function-register bus at a parameterised address, 0x87 by default. Bit 0 requests idle. Bit 1 requests power-down. This block only stores the power-down bit and reports it as a peripheral clock-enable request; the clock stopping itself belongs to another block. Bits 7..2 are plain storage bits that read back as written.

Top module: `idle_ctrl`

## Requirements
- R1: In the cycle after synchronous reset the register reads 0x00, `cpu_halt` is 0, `wake` is 0 and `periph_clk_en` is 1.
- R2: When `sfr_addr` equals the register address (0x87), `sfr_hit` is 1 and `sfr_rdata` shows the register contents combinationally. A write with `sfr_wr`=1 at that address stores all 8 bits of `sfr_wdata` at the clock edge.
- R3: A write to any other address leaves the register, `cpu_halt` and `periph_clk_en` unchanged.
- R4: `cpu_halt` rises in the cycle after a register write with bit 0 = 1, provided `irq_pending` is 0. It rises at no other time.
- R5: While `cpu_halt` is 1 and bit 1 = 0, `periph_clk_en` stays 1, so the peripherals keep running.
- R6: While bit 0 = 1, `irq_pending` = 1 forces `cpu_halt` to 0 and `wake` to 1 in that same cycle. Bit 0 reads 0 after the next edge, and bits 7..1 are kept.
- R7: `irq_pending` while bit 0 = 0 has no effect: `wake` stays 0 and the register is unchanged.
- R8: `periph_clk_en` is the inverse of register bit 1 (power-down request). An interrupt does not clear bit 1.
- R9: When `sfr_addr` is not the register address, `sfr_hit` is 0 and `sfr_rdata` is 0x00.
- R10: A register write with bit 0 = 0 ends idle: `cpu_halt` is 0 from the next cycle.
- R11: When a register write and an interrupt-driven clear fall in the same cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Register contents when addressed, otherwise 0 |
| sfr_hit | output | 1 | Address matches the power-control register |
| irq_pending | input | 1 | Interrupt pending from the interrupt controller |
| cpu_halt | output | 1 | Halts the CPU core while idle |
| wake | output | 1 | Idle is being ended by an interrupt in this cycle |
| periph_clk_en | output | 1 | Peripheral clock-enable request (low on power-down) |

## Verification
Almost all register state is visible through `sfr_rdata` on any cycle in which the register is addressed. A stored value that is wrong shows up there at once. It also shows in `cpu_halt` and `periph_clk_en` one edge after the write that caused it.

An idle bit that fails to clear shows as `cpu_halt` coming back high in the cycle after `irq_pending` falls. An idle bit that clears without cause shows as `cpu_halt` dropping with no interrupt present.

The bench compares every output in every cycle against a byte-wide reference model. A fault is therefore reported no more than one cycle after it first appears at the ports.

// File: rtl/idle_pkg.sv
package idle_pkg;

    localparam int DATA_W   = 8;
    localparam int IDLE_POS = 0;
    localparam int PD_POS   = 1;

    typedef struct packed {
        logic [DATA_W-3:0] spare;
        logic              pd;
        logic              idle;
    } pcon_t;

    typedef struct packed {
        logic              wr;
        logic              hit;
        logic [DATA_W-1:0] wdata;
    } sfr_req_t;

    function automatic pcon_t to_pcon(input logic [DATA_W-1:0] v);
        pcon_t p;
        p = pcon_t'(v);
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] from_pcon(input pcon_t p);
        return DATA_W'(p);
    endfunction

endpackage

// File: rtl/idle_sfr_decode.sv
module idle_sfr_decode #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  PCON_ADDR = 8'h87
) (
    input  logic [ADDR_W-1:0]        sfr_addr,
    input  logic                     sfr_wr,
    input  logic [idle_pkg::DATA_W-1:0] sfr_wdata,
    output idle_pkg::sfr_req_t       req
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PCON_ADDR);

    always_comb begin
        req.hit   = (sfr_addr == MATCH);
        req.wr    = sfr_wr && (sfr_addr == MATCH);
        req.wdata = sfr_wdata;
    end
endmodule

// File: rtl/idle_pcon_reg.sv
module idle_pcon_reg
    import idle_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sfr_req_t req,
    input  logic     hw_clear_idle,
    output pcon_t    pcon_q
);
    pcon_t pcon_d;

    always_comb begin
        pcon_d = pcon_q;
        if (req.wr) begin
            pcon_d = to_pcon(req.wdata);
        end else if (hw_clear_idle) begin
            pcon_d.idle = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pcon_q <= '0;
        else     pcon_q <= pcon_d;
    end
endmodule

// File: rtl/idle_halt_ctrl.sv
module idle_halt_ctrl
    import idle_pkg::*;
(
    input  pcon_t pcon_q,
    input  logic  irq_pending,
    output logic  cpu_halt,
    output logic  wake,
    output logic  periph_clk_en
);
    always_comb begin
        wake          = pcon_q.idle && irq_pending;
        cpu_halt      = pcon_q.idle && !irq_pending;
        periph_clk_en = !pcon_q.pd;
    end
endmodule

// File: rtl/idle_ctrl.sv
module idle_ctrl
    import idle_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] PCON_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    output logic              sfr_hit,
    input  logic              irq_pending,
    output logic              cpu_halt,
    output logic              wake,
    output logic              periph_clk_en
);
    sfr_req_t req;
    pcon_t    pcon_q;
    logic     wake_int;

    idle_sfr_decode #(.ADDR_W(ADDR_W), .PCON_ADDR(PCON_ADDR)) dec_i (
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .req       (req)
    );

    idle_pcon_reg reg_i (
        .clk           (clk),
        .rst           (rst),
        .req           (req),
        .hw_clear_idle (wake_int),
        .pcon_q        (pcon_q)
    );

    idle_halt_ctrl hc_i (
        .pcon_q        (pcon_q),
        .irq_pending   (irq_pending),
        .cpu_halt      (cpu_halt),
        .wake          (wake_int),
        .periph_clk_en (periph_clk_en)
    );

    assign wake      = wake_int;
    assign sfr_hit   = req.hit;
    assign sfr_rdata = req.hit ? from_pcon(pcon_q) : '0;
endmodule

// File: rtl/idle_ctrl_chk.sv
module idle_ctrl_chk #(
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] PCON_ADDR = 8'h87
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_wr,
    input logic [7:0]        sfr_wdata,
    input logic [7:0]        sfr_rdata,
    input logic              sfr_hit,
    input logic              irq_pending,
    input logic              cpu_halt,
    input logic              wake,
    input logic              periph_clk_en
);
    logic wr_hit;
    assign wr_hit = sfr_wr && (sfr_addr == ADDR_W'(PCON_ADDR));

    // R4: halt only rises after a register write that set bit 0
    assert_halt_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_halt) |-> $past(wr_hit && sfr_wdata[0]));

    // R6: a pending interrupt always releases the CPU
    assert_irq_releases_R6: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> !cpu_halt);

    // R6: after a wake without a colliding write, halt stays low
    assert_wake_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (wake && !wr_hit) |=> !cpu_halt && !wake);

    // R3/R8: clock enable only changes after a register write
    assert_clk_en_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_hit) |-> $stable(periph_clk_en));

    // R9: unaddressed reads return zero
    assert_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !sfr_hit |-> (sfr_rdata == 8'h00));

    // R7: no wake while not halted in the previous cycle and no write
    assert_no_spurious_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (!cpu_halt && !wake && !wr_hit) |=> !wake || !$past(sfr_hit && sfr_rdata[0] == 1'b0));
endmodule

bind idle_ctrl idle_ctrl_chk #(.ADDR_W(ADDR_W), .PCON_ADDR(PCON_ADDR)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .sfr_addr      (sfr_addr),
    .sfr_wr        (sfr_wr),
    .sfr_wdata     (sfr_wdata),
    .sfr_rdata     (sfr_rdata),
    .sfr_hit       (sfr_hit),
    .irq_pending   (irq_pending),
    .cpu_halt      (cpu_halt),
    .wake          (wake),
    .periph_clk_en (periph_clk_en)
);

// File: tb/idle_ctrl_tb.sv
`timescale 1ns/1ps
module idle_ctrl_tb_top;
    localparam logic [7:0] PCON = 8'h87;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] sfr_addr;
    logic       sfr_wr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;
    logic       sfr_hit;
    logic       irq_pending;
    logic       cpu_halt;
    logic       wake;
    logic       periph_clk_en;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;
    logic [7:0] m_reg;

    always #2.5 clk = ~clk;

    idle_ctrl dut_i (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
        .irq_pending(irq_pending), .cpu_halt(cpu_halt), .wake(wake),
        .periph_clk_en(periph_clk_en)
    );

    function automatic logic [7:0] next_reg(input logic [7:0] cur, input logic [7:0] a,
                                            input logic w, input logic [7:0] d, input logic irq);
        logic [7:0] n;
        n = cur;
        if (w && a == PCON) n = d;
        else if (cur[0] && irq) n[0] = 1'b0;
        return n;
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic hit_e;
        hit_e = (sfr_addr == PCON);
        chk(hit_e ? "R2" : "R9", {tag, " hit"}, {7'd0, sfr_hit}, {7'd0, hit_e});
        chk(hit_e ? "R2" : "R9", {tag, " rdata"}, sfr_rdata, hit_e ? m_reg : 8'h00);
        chk(irq_pending ? "R6" : "R4", {tag, " halt"}, {7'd0, cpu_halt}, {7'd0, m_reg[0] & ~irq_pending});
        chk(m_reg[0] ? "R6" : "R7", {tag, " wake"}, {7'd0, wake}, {7'd0, m_reg[0] & irq_pending});
        chk(cpu_halt ? "R5" : "R8", {tag, " clk_en"}, {7'd0, periph_clk_en}, {7'd0, ~m_reg[1]});
    endtask

    // drive at negedge, check after settle, then advance model at posedge
    task automatic step(input string tag, input logic [7:0] a, input logic w,
                        input logic [7:0] d, input logic irq);
        @(negedge clk);
        sfr_addr = a; sfr_wr = w; sfr_wdata = d; irq_pending = irq;
        #1;
        check_outputs(tag);
        @(posedge clk);
        m_reg = next_reg(m_reg, a, w, d, irq);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; sfr_addr = 8'h00; sfr_wr = 1'b0; sfr_wdata = 8'h00; irq_pending = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; m_reg = 8'h00;
        sfr_addr = PCON; #1;
        // R1: reset state
        chk("R1", "reset rdata", sfr_rdata, 8'h00);
        chk("R1", "reset halt", {7'd0, cpu_halt}, 8'h00);
        chk("R1", "reset wake", {7'd0, wake}, 8'h00);
        chk("R1", "reset clk_en", {7'd0, periph_clk_en}, 8'h01);

        // R4: enter idle, halt next cycle
        step("R4 write idle", PCON, 1'b1, 8'hA1, 1'b0);
        step("R5 idle hold", 8'h10, 1'b0, 8'h00, 1'b0);
        step("R5 idle hold2", PCON, 1'b0, 8'h00, 1'b0);
        // R3: write elsewhere ignored while halted
        step("R3 other write", 8'h86, 1'b1, 8'h00, 1'b0);
        step("R3 after", PCON, 1'b0, 8'h00, 1'b0);
        // R6: interrupt wakes
        step("R6 irq", PCON, 1'b0, 8'h00, 1'b1);
        step("R6 after", PCON, 1'b0, 8'h00, 1'b0);
        // R7: interrupt while not idle
        step("R7 irq idle0", PCON, 1'b0, 8'h00, 1'b1);
        step("R7 after", PCON, 1'b0, 8'h00, 1'b0);
        // R8: power-down bit survives interrupt
        step("R8 set pd+idle", PCON, 1'b1, 8'h03, 1'b0);
        step("R8 irq", PCON, 1'b0, 8'h00, 1'b1);
        step("R8 after", PCON, 1'b0, 8'h00, 1'b0);
        // R10: software clear of idle
        step("R10 set", PCON, 1'b1, 8'h01, 1'b0);
        step("R10 clear", PCON, 1'b1, 8'h00, 1'b0);
        step("R10 after", PCON, 1'b0, 8'h00, 1'b0);
        // R11: write wins over wake
        step("R11 set", PCON, 1'b1, 8'h01, 1'b0);
        step("R11 collide", PCON, 1'b1, 8'h45, 1'b1);
        step("R11 after", PCON, 1'b0, 8'h00, 1'b0);
        // R6: interrupt held across a set-idle write
        step("R6 irq held w", PCON, 1'b1, 8'h01, 1'b1);
        step("R6 irq held", PCON, 1'b0, 8'h00, 1'b1);
        step("R6 irq drop", PCON, 1'b0, 8'h00, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            a = ($urandom % 2 == 0) ? PCON : 8'($urandom);
            step("rand", a, ($urandom % 3) == 0, 8'($urandom), ($urandom % 5) == 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule